// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block shifts a 32-bit operand by an amount taken from the low byte of a second 32-bit operand. It supports four shift kinds: logical left, logical right, arithmetic right and rotate right. Along with the shifted value it produces a carry bit and a carry-valid flag. The carry-valid flag tells the surrounding core whether its carry flag should be overwritten.

There are two modes. In flag-setting mode, amounts of 32 and above follow separate result and carry rules for each shift kind. In plain mode no carry is produced, and out-of-range amounts are simply saturated. The block captures one request per cycle when `inValid` is high. It presents the registered answer one cycle later, with `outValid` high for one cycle.

Top module: `shift_carry_top`

## Requirements
- R1: Only bits 7:0 of `amount` take part. Bits 31:8 have no effect on any output.
- R2: Logical left (shiftType 2'b00) in flag mode works as follows. For amounts 1..31 the result is operand << amount and carry is operand bit (32-amount). For amount 32 the result is 0 and carry is operand bit 0. Above 32 both result and carry are 0. carryValid is 1 in all of these cases.
- R3: Logical right (shiftType 2'b01) in flag mode works as follows. For amounts 1..31 the result is operand >> amount and carry is operand bit (amount-1). For amount 32 the result is 0 and carry is operand bit 31. Above 32 both result and carry are 0. carryValid is 1.
- R4: Arithmetic right (shiftType 2'b10) in flag mode works as follows. For amounts 1..31 the result is the sign-filled shift and carry is bit (amount-1). For amounts 32..255 every result bit equals operand bit 31, and so does carry. carryValid is 1.
- R5: Rotate right (shiftType 2'b11) in flag mode rotates by amount mod 32, and carry is the bit that lands in result bit 31. When amount mod 32 is 0 but the 8-bit amount is nonzero, the result equals the operand, carry is operand bit 31 and carryValid is 1.
- R6: For every shift kind and both modes, an 8-bit amount of 0 returns the operand unchanged with carryValid = 0 and carryOut = 0.
- R7: In plain mode (setFlags = 0), carryValid and carryOut are always 0. Logical shifts of 32 or more give 0. An arithmetic right shift of 32 or more acts as a shift by 31. Shifts below 32 give the same result as in flag mode.
- R8: A request accepted with `inValid` appears on `result`, `carryOut` and `carryValid` exactly one cycle later, with `outValid` high for that cycle only. Reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| shiftType | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| setFlags | input | 1 | 1 selects flag-setting mode |
| operand | input | 32 | Value to shift |
| amount | input | 32 | Shift amount; only bits 7:0 are used |
| outValid | output | 1 | Result strobe, one cycle after request |
| result | output | 32 | Shifted value |
| carryOut | output | 1 | Carry produced by the shift |
| carryValid | output | 1 | High when the carry flag should be updated |

## Verification
Two rules can apply to the same request. The zero-amount rule, which leaves carry alone, can meet the out-of-range rules. This happens whenever the low byte of `amount` is 0 while its upper bits are set. It also happens when a rotate amount is a nonzero multiple of 32, which gives the same rotation as amount 0 but must still update carry. The table sets these requests side by side: 0x00000000 and 0xFFFFFF00 against 64 and 224 for rotate, and 0x104 against 4. Each is judged on whether carryValid is raised and on the exact carry bit and result.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = 8;
  localparam int SH_W   = $clog2(DATA_W);

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shiftKind_e;

  typedef struct packed {
    shiftKind_e       kind;
    logic             setFlags;
    logic             amtZero;   // full 8-bit amount is zero
    logic             amtEqW;    // amount equals the data width
    logic             amtOverW;  // amount exceeds the data width
    logic             rotWrap;   // nonzero amount, zero modulo width
    logic [SH_W-1:0]  sh;        // amount modulo width
  } ctrlStrobes_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic [1:0]        shiftType,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] amount,
  output ctrlStrobes_t      strobes
);
  logic [AMT_W-1:0] amtLow;

  always_comb begin
    amtLow           = amount[AMT_W-1:0];
    strobes.kind     = shiftKind_e'(shiftType);
    strobes.setFlags = setFlags;
    strobes.amtZero  = (amtLow == '0);
    strobes.amtEqW   = (amtLow == AMT_W'(DATA_W));
    strobes.amtOverW = (amtLow > AMT_W'(DATA_W));
    strobes.sh       = amtLow[SH_W-1:0];
    strobes.rotWrap  = (amtLow[SH_W-1:0] == '0) && (amtLow != '0);
  end
endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  input  ctrlStrobes_t      strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryValid
);
  logic [DATA_W-1:0]          lslRes, lsrRes, asrRes, rorRes;
  logic                       lslC, lsrC, asrC, rorC;
  logic signed [DATA_W:0]     asrExt;
  logic [2*DATA_W-1:0]        rotDbl;
  logic [DATA_W-1:0]          nxtRes;
  logic                       nxtC, nxtCv, bigAmt, signBit;

  // Each shifter is widened by one bit so the last bit shifted out is the carry.
  always_comb begin
    {lslC, lslRes} = {1'b0, operand} << strobes.sh;
    {lsrRes, lsrC} = {operand, 1'b0} >> strobes.sh;
    asrExt         = $signed({operand, 1'b0}) >>> strobes.sh;
    {asrRes, asrC} = asrExt;
    rotDbl         = {operand, operand} >> strobes.sh;
    rorRes         = rotDbl[DATA_W-1:0];
    rorC           = rorRes[DATA_W-1];
  end

  always_comb begin
    bigAmt  = strobes.amtEqW | strobes.amtOverW;
    signBit = operand[DATA_W-1];
    nxtRes  = operand;
    nxtC    = 1'b0;
    nxtCv   = 1'b0;
    if (!strobes.amtZero) begin
      nxtCv = strobes.setFlags;
      unique case (strobes.kind)
        KIND_LSL: begin
          nxtRes = bigAmt ? '0 : lslRes;
          nxtC   = bigAmt ? (strobes.amtEqW & operand[0]) : lslC;
        end
        KIND_LSR: begin
          nxtRes = bigAmt ? '0 : lsrRes;
          nxtC   = bigAmt ? (strobes.amtEqW & signBit) : lsrC;
        end
        KIND_ASR: begin
          nxtRes = bigAmt ? {DATA_W{signBit}} : asrRes;
          nxtC   = bigAmt ? signBit : asrC;
        end
        KIND_ROR: begin
          nxtRes = strobes.rotWrap ? operand : rorRes;
          nxtC   = strobes.rotWrap ? signBit : rorC;
        end
        default: ;
      endcase
      nxtC = nxtC & strobes.setFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      result     <= '0;
      carryOut   <= 1'b0;
      carryValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result     <= nxtRes;
        carryOut   <= nxtC;
        carryValid <= nxtCv;
      end
    end
  end

  // R7: no carry leaves the block without its valid flag
  p_carry_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> carryValid);
endmodule

// File: rtl/shift_carry_top.sv
module shift_carry_top
  import shift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        shiftType,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] amount,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryValid
);
  ctrlStrobes_t strobes;

  shift_ctrl ctrl_i (
    .shiftType (shiftType),
    .setFlags  (setFlags),
    .amount    (amount),
    .strobes   (strobes)
  );

  shift_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .operand    (operand),
    .strobes    (strobes),
    .outValid   (outValid),
    .result     (result),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && amount[AMT_W-1:0] == '0) |=>
      (result == $past(operand) && !carryValid && !carryOut));
  p_plain_no_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !setFlags) |=> (!carryValid && !carryOut));
  p_asr_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shiftType == 2'b10 && amount[AMT_W-1:0] >= AMT_W'(DATA_W)) |=>
      (result == {DATA_W{$past(operand[DATA_W-1])}}));
  p_lsl_far_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shiftType == 2'b00 && amount[AMT_W-1:0] > AMT_W'(DATA_W)) |=>
      (result == '0 && !carryOut));
endmodule

// File: tb/shift_carry_top_tb_top.sv
`timescale 1ns/100ps
module shift_carry_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  shiftType = 2'b00;
  logic        setFlags = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] amount = '0;
  logic        outValid, carryOut, carryValid;
  logic [31:0] result;

  int applied = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  shift_carry_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .shiftType(shiftType),
    .setFlags(setFlags), .operand(operand), .amount(amount),
    .outValid(outValid), .result(result), .carryOut(carryOut),
    .carryValid(carryValid)
  );

  // {kind, flags, operand, amount, expResult, expCarry, expCarryValid, reqNo}
  localparam int NV = 32;
  localparam logic [104:0] VEC [NV] = '{
    {2'd0, 1'b1, 32'h80000001, 32'd4,        32'h00000010, 1'b0, 1'b1, 4'd2}, // R2
    {2'd0, 1'b1, 32'h80000001, 32'd1,        32'h00000002, 1'b1, 1'b1, 4'd2}, // R2
    {2'd0, 1'b1, 32'h80000001, 32'd32,       32'h00000000, 1'b1, 1'b1, 4'd2}, // R2
    {2'd0, 1'b1, 32'h80000001, 32'd33,       32'h00000000, 1'b0, 1'b1, 4'd2}, // R2
    {2'd0, 1'b1, 32'h00000001, 32'd31,       32'h80000000, 1'b0, 1'b1, 4'd2}, // R2
    {2'd1, 1'b1, 32'h80000001, 32'd1,        32'h40000000, 1'b1, 1'b1, 4'd3}, // R3
    {2'd1, 1'b1, 32'h80000001, 32'd32,       32'h00000000, 1'b1, 1'b1, 4'd3}, // R3
    {2'd1, 1'b1, 32'h80000001, 32'd200,      32'h00000000, 1'b0, 1'b1, 4'd3}, // R3
    {2'd1, 1'b1, 32'h80000000, 32'd31,       32'h00000001, 1'b0, 1'b1, 4'd3}, // R3
    {2'd2, 1'b1, 32'h80000001, 32'd4,        32'hF8000000, 1'b0, 1'b1, 4'd4}, // R4
    {2'd2, 1'b1, 32'h80000001, 32'd40,       32'hFFFFFFFF, 1'b1, 1'b1, 4'd4}, // R4
    {2'd2, 1'b1, 32'h70000000, 32'd255,      32'h00000000, 1'b0, 1'b1, 4'd4}, // R4
    {2'd2, 1'b1, 32'h80000008, 32'd4,        32'hF8000000, 1'b1, 1'b1, 4'd4}, // R4
    {2'd3, 1'b1, 32'h80000001, 32'd1,        32'hC0000000, 1'b1, 1'b1, 4'd5}, // R5
    {2'd3, 1'b1, 32'h80000001, 32'd64,       32'h80000001, 1'b1, 1'b1, 4'd5}, // R5
    {2'd3, 1'b1, 32'h00000010, 32'd36,       32'h00000001, 1'b0, 1'b1, 4'd5}, // R5
    {2'd3, 1'b1, 32'h00000010, 32'd37,       32'h80000000, 1'b1, 1'b1, 4'd5}, // R5
    {2'd3, 1'b1, 32'h7FFFFFFF, 32'd224,      32'h7FFFFFFF, 1'b0, 1'b1, 4'd5}, // R5
    {2'd0, 1'b1, 32'h80000001, 32'd0,        32'h80000001, 1'b0, 1'b0, 4'd6}, // R6
    {2'd2, 1'b1, 32'h80000001, 32'd0,        32'h80000001, 1'b0, 1'b0, 4'd6}, // R6
    {2'd3, 1'b1, 32'h80000001, 32'd0,        32'h80000001, 1'b0, 1'b0, 4'd6}, // R6
    {2'd1, 1'b0, 32'hDEADBEEF, 32'd0,        32'hDEADBEEF, 1'b0, 1'b0, 4'd6}, // R6
    {2'd0, 1'b1, 32'h80000001, 32'h00000104, 32'h00000010, 1'b0, 1'b1, 4'd1}, // R1
    {2'd3, 1'b1, 32'h80000001, 32'hFFFFFF00, 32'h80000001, 1'b0, 1'b0, 4'd1}, // R1
    {2'd1, 1'b1, 32'h80000001, 32'h12345620, 32'h00000000, 1'b1, 1'b1, 4'd1}, // R1
    {2'd0, 1'b0, 32'h80000001, 32'd32,       32'h00000000, 1'b0, 1'b0, 4'd7}, // R7
    {2'd1, 1'b0, 32'h80000001, 32'd40,       32'h00000000, 1'b0, 1'b0, 4'd7}, // R7
    {2'd2, 1'b0, 32'h80000001, 32'd100,      32'hFFFFFFFF, 1'b0, 1'b0, 4'd7}, // R7
    {2'd2, 1'b0, 32'h40000000, 32'd50,       32'h00000000, 1'b0, 1'b0, 4'd7}, // R7
    {2'd0, 1'b0, 32'h80000001, 32'd4,        32'h00000010, 1'b0, 1'b0, 4'd7}, // R7
    {2'd3, 1'b0, 32'h80000001, 32'd64,       32'h80000001, 1'b0, 1'b0, 4'd7}, // R7
    {2'd3, 1'b0, 32'h80000001, 32'd1,        32'hC0000000, 1'b0, 1'b0, 4'd7}  // R7
  };

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {result,carry,valid} actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [104:0] v);
    shiftType = v[104:103];
    setFlags  = v[102];
    operand   = v[101:70];
    amount    = v[69:38];
    inValid   = 1'b1;
  endtask

  initial begin : watchdog
    #500000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", {result, carryOut, 1'b0}, 34'd0);
    check("R8", {32'd0, outValid, carryValid}, 34'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i),
            {result, carryOut, carryValid}, VEC[i][37:4]);
      check("R8 outValid pulse", {33'd0, outValid}, 34'd1);
      @(negedge clk);
      check("R8 outValid drop", {33'd0, outValid}, 34'd0);
    end

    // R8: back-to-back requests, each answer in the following cycle
    drive(VEC[1]);
    @(negedge clk);
    check("R8 b2b first", {result, carryOut, carryValid}, VEC[1][37:4]);
    drive(VEC[18]);
    @(negedge clk);
    check("R8 b2b zero after carry", {result, carryOut, carryValid}, VEC[18][37:4]);
    drive(VEC[10]);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 b2b third", {result, carryOut, carryValid}, VEC[10][37:4]);
    check("R8 b2b valid", {33'd0, outValid}, 34'd1);

    // R8: reset mid-stream clears outputs
    drive(VEC[0]);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R8 reset clear", {result, carryOut, carryValid}, 34'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule